// File: doc/BRIEF.md
# Ready-Warp Issue Scheduler

This block picks at most one warp per clock to issue an instruction from the pool of warps resident in one processing partition. For each warp slot it holds a resident flag, a per-register pending scoreboard and an outstanding-load flag. The barrier unit holds a wait flag for each warp and a partition-wide arrival counter. A warp may issue only when none of three independent blockers applies: a pending source register, an outstanding load that its next instruction needs, or a wait at the barrier. A warp that is blocked keeps its slot and its state, and the issue slot goes to another warp.

The surrounding pipeline presents, for every slot, the source and destination register indices and the kind of the warp's next instruction. It also reports allocate and retire events, register writebacks, load completions and barrier arrivals. Among the ready warps, the grant rotates round-robin, starting from the slot after the last grant. The grant is combinational from the registered state and the current instruction fields. It takes effect on the state at the next rising edge.

Top module: `wsched_issue`

## Requirements
- R1: After reset no warp is resident and issue_valid_o is low.
- R2: At most one warp is granted per cycle, and a granted warp is always resident and not waiting at the barrier.
- R3: A warp is ready only if neither of its source registers is pending. Issuing an instruction with has_dst set marks its destination register pending from the next cycle on. A writeback with the same warp and register clears that bit.
- R4: When a writeback and an issue of the same warp target the same register in the same cycle, the register stays pending.
- R5: Issuing a load sets the warp's outstanding-load flag and a load-done event clears it. If both happen in the same cycle, the flag is set. The flag blocks the warp only while its next instruction has dep_load set.
- R6: A barrier arrival from a resident warp that is not already waiting sets its wait flag and adds one to the arrival count. An arrival from a non-resident or already waiting warp has no effect. A waiting warp is never granted.
- R7: When the arrival count is nonzero and equals the number of resident warps, one edge clears every wait flag and the count. The released warps can be granted from the next cycle.
- R8: The grant goes to the first ready warp found when searching upward, with wrap-around, from the slot after the last granted warp. After reset the search starts at slot 0.
- R9: issue_valid_o is low in any cycle in which no warp is ready.
- R10: Allocation makes a slot resident and clears its scoreboard, its load flag and its wait flag. Retire removes the slot and its wait flag, and lowers the count if the warp was waiting. When allocate and retire name the same slot in one cycle, allocation wins.
- R11: Blocked warps are skipped without losing a cycle: whenever some warp is ready, issue_valid_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Allocate a warp slot |
| alloc_warp_i | input | WID_W | Slot to allocate |
| retire_valid_i | input | 1 | Retire a warp slot |
| retire_warp_i | input | WID_W | Slot to retire |
| src_a_i | input | NUM_WARPS*REG_W | First source register of each warp's next instruction, slot w at bits [w*REG_W +: REG_W] |
| src_b_i | input | NUM_WARPS*REG_W | Second source register, same packing |
| dst_i | input | NUM_WARPS*REG_W | Destination register, same packing |
| has_dst_i | input | NUM_WARPS | Next instruction writes dst |
| is_load_i | input | NUM_WARPS | Next instruction is a memory load |
| dep_load_i | input | NUM_WARPS | Next instruction needs the outstanding load |
| wb_valid_i | input | 1 | Register writeback event |
| wb_warp_i | input | WID_W | Writeback warp |
| wb_reg_i | input | REG_W | Writeback register |
| ld_done_valid_i | input | 1 | Load completion event |
| ld_done_warp_i | input | WID_W | Warp whose load completed |
| bar_arrive_valid_i | input | 1 | Barrier arrival event |
| bar_arrive_warp_i | input | WID_W | Arriving warp |
| issue_valid_o | output | 1 | A warp is granted this cycle |
| issue_warp_o | output | WID_W | Granted warp |

## Verification
On every cycle, the embedded assertions check the following. The grant always names a resident warp that is not waiting. Some warp is granted exactly when some warp is ready. The scoreboard and load flags hold their set state after an issue, even when a writeback lands in the same cycle. The arrival count always equals the number of waiting warps, and a release leaves the count and every wait flag at zero. The round-robin pointer follows the grant. Only the bench's scenarios can show the following, where a behavioural model predicts the grant every cycle. The grant order rotates fairly under real stalls. A barrier opens exactly when the last resident warp arrives, including after a waiting warp retires. Duplicate arrivals and arrivals from empty slots leave the release point unchanged.

// File: rtl/wsched_pkg.sv
`timescale 1ns/1ps
package wsched_pkg;
  // Kind bits of a warp's next instruction
  typedef struct packed {
    logic has_dst;
    logic is_load;
    logic dep_load;
  } inst_flags_t;
endpackage

// File: rtl/wsched_warp_ctx.sv
`timescale 1ns/1ps
module wsched_warp_ctx
  import wsched_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic             retire_i,
  input  logic             issue_i,
  input  logic [REG_W-1:0] src_a_i,
  input  logic [REG_W-1:0] src_b_i,
  input  logic [REG_W-1:0] dst_i,
  input  inst_flags_t      flags_i,
  input  logic             wb_i,
  input  logic [REG_W-1:0] wb_reg_i,
  input  logic             ld_done_i,
  output logic             valid_o,
  output logic             ready_o
);

  logic                valid_q;
  logic                ld_pend_q;
  logic [NUM_REGS-1:0] pend_q, pend_d;
  logic                ld_pend_d;

  always_comb begin
    pend_d = pend_q;
    if (wb_i) pend_d[wb_reg_i] = 1'b0;
    // set after clear: a same-cycle issue keeps the register pending
    if (issue_i && flags_i.has_dst) pend_d[dst_i] = 1'b1;
    ld_pend_d = ld_pend_q;
    if (ld_done_i) ld_pend_d = 1'b0;
    if (issue_i && flags_i.is_load) ld_pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      ld_pend_q <= 1'b0;
      pend_q    <= '0;
    end else if (alloc_i) begin
      valid_q   <= 1'b1;
      ld_pend_q <= 1'b0;
      pend_q    <= '0;
    end else begin
      if (retire_i) valid_q <= 1'b0;
      ld_pend_q <= ld_pend_d;
      pend_q    <= pend_d;
    end
  end

  assign valid_o = valid_q;
  assign ready_o = valid_q && !pend_q[src_a_i] && !pend_q[src_b_i]
                   && !(ld_pend_q && flags_i.dep_load);

  // R3
  dst_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && flags_i.has_dst && !alloc_i) |=> pend_q[$past(dst_i)]);
  // R4
  wb_race_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && flags_i.has_dst && wb_i && wb_reg_i == dst_i && !alloc_i)
      |=> pend_q[$past(wb_reg_i)]);
  // R5
  ld_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && flags_i.is_load && !alloc_i) |=> ld_pend_q);
  // R10
  alloc_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |=> (valid_q && pend_q == '0 && !ld_pend_q));

endmodule

// File: rtl/wsched_barrier.sv
`timescale 1ns/1ps
module wsched_barrier #(
  parameter int NUM_WARPS = 16,
  localparam int WID_W = $clog2(NUM_WARPS),
  localparam int CNT_W = $clog2(NUM_WARPS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_WARPS-1:0] valid_i,
  input  logic [NUM_WARPS-1:0] clear_i,
  input  logic                 arrive_valid_i,
  input  logic [WID_W-1:0]     arrive_warp_i,
  output logic [NUM_WARPS-1:0] wait_o
);

  logic [NUM_WARPS-1:0] wait_q, wait_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic                 arr_ok, release_w;

  assign arr_ok    = arrive_valid_i && valid_i[arrive_warp_i] && !wait_q[arrive_warp_i];
  assign release_w = (cnt_q != '0) && (int'(cnt_q) == $countones(valid_i));

  always_comb begin
    wait_d = '0;
    cnt_d  = '0;
    if (!release_w) begin
      for (int w = 0; w < NUM_WARPS; w++) begin
        wait_d[w] = !clear_i[w] &&
                    (wait_q[w] || (arr_ok && arrive_warp_i == WID_W'(w)));
      end
      cnt_d = cnt_q
            + CNT_W'(arr_ok && !clear_i[arrive_warp_i])
            - CNT_W'($countones(clear_i & wait_q));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= '0;
      cnt_q  <= '0;
    end else begin
      wait_q <= wait_d;
      cnt_q  <= cnt_d;
    end
  end

  assign wait_o = wait_q;

  // R6
  cnt_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) == $countones(wait_q));
  // R7
  release_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_w |=> (cnt_q == '0 && wait_q == '0));

endmodule

// File: rtl/wsched_rr_arb.sv
`timescale 1ns/1ps
module wsched_rr_arb #(
  parameter int NUM_WARPS = 16,
  localparam int WID_W = $clog2(NUM_WARPS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_WARPS-1:0] req_i,
  output logic                 gnt_valid_o,
  output logic [WID_W-1:0]     gnt_idx_o
);

  logic [WID_W-1:0] last_q;

  always_comb begin
    gnt_valid_o = 1'b0;
    gnt_idx_o   = '0;
    for (int k = 1; k <= NUM_WARPS; k++) begin
      int idx;
      idx = (int'(last_q) + k) % NUM_WARPS;
      if (!gnt_valid_o && req_i[idx]) begin
        gnt_valid_o = 1'b1;
        gnt_idx_o   = WID_W'(idx);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          last_q <= WID_W'(NUM_WARPS - 1);
    else if (gnt_valid_o) last_q <= gnt_idx_o;
  end

  // R8
  rr_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o |=> last_q == $past(gnt_idx_o));

endmodule

// File: rtl/wsched_issue.sv
`timescale 1ns/1ps
module wsched_issue
  import wsched_pkg::*;
#(
  parameter int NUM_WARPS = 16,
  parameter int NUM_REGS  = 32,
  localparam int WID_W = $clog2(NUM_WARPS),
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       alloc_valid_i,
  input  logic [WID_W-1:0]           alloc_warp_i,
  input  logic                       retire_valid_i,
  input  logic [WID_W-1:0]           retire_warp_i,
  input  logic [NUM_WARPS*REG_W-1:0] src_a_i,
  input  logic [NUM_WARPS*REG_W-1:0] src_b_i,
  input  logic [NUM_WARPS*REG_W-1:0] dst_i,
  input  logic [NUM_WARPS-1:0]       has_dst_i,
  input  logic [NUM_WARPS-1:0]       is_load_i,
  input  logic [NUM_WARPS-1:0]       dep_load_i,
  input  logic                       wb_valid_i,
  input  logic [WID_W-1:0]           wb_warp_i,
  input  logic [REG_W-1:0]           wb_reg_i,
  input  logic                       ld_done_valid_i,
  input  logic [WID_W-1:0]           ld_done_warp_i,
  input  logic                       bar_arrive_valid_i,
  input  logic [WID_W-1:0]           bar_arrive_warp_i,
  output logic                       issue_valid_o,
  output logic [WID_W-1:0]           issue_warp_o
);

  logic [NUM_WARPS-1:0] warp_valid;
  logic [NUM_WARPS-1:0] ctx_ready;
  logic [NUM_WARPS-1:0] bar_wait;
  logic [NUM_WARPS-1:0] slot_clear;
  logic [NUM_WARPS-1:0] req;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    inst_flags_t fl;
    logic        alloc_hit, retire_hit;
    assign fl.has_dst  = has_dst_i[w];
    assign fl.is_load  = is_load_i[w];
    assign fl.dep_load = dep_load_i[w];
    assign alloc_hit   = alloc_valid_i  && alloc_warp_i  == WID_W'(w);
    assign retire_hit  = retire_valid_i && retire_warp_i == WID_W'(w);
    assign slot_clear[w] = alloc_hit || retire_hit;

    wsched_warp_ctx #(.NUM_REGS(NUM_REGS)) u_ctx (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .alloc_i   (alloc_hit),
      .retire_i  (retire_hit),
      .issue_i   (issue_valid_o && issue_warp_o == WID_W'(w)),
      .src_a_i   (src_a_i[w*REG_W +: REG_W]),
      .src_b_i   (src_b_i[w*REG_W +: REG_W]),
      .dst_i     (dst_i[w*REG_W +: REG_W]),
      .flags_i   (fl),
      .wb_i      (wb_valid_i && wb_warp_i == WID_W'(w)),
      .wb_reg_i  (wb_reg_i),
      .ld_done_i (ld_done_valid_i && ld_done_warp_i == WID_W'(w)),
      .valid_o   (warp_valid[w]),
      .ready_o   (ctx_ready[w])
    );
  end

  wsched_barrier #(.NUM_WARPS(NUM_WARPS)) u_bar (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .valid_i        (warp_valid),
    .clear_i        (slot_clear),
    .arrive_valid_i (bar_arrive_valid_i),
    .arrive_warp_i  (bar_arrive_warp_i),
    .wait_o         (bar_wait)
  );

  assign req = ctx_ready & ~bar_wait;

  wsched_rr_arb #(.NUM_WARPS(NUM_WARPS)) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req),
    .gnt_valid_o (issue_valid_o),
    .gnt_idx_o   (issue_warp_o)
  );

  // R2
  issue_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> (warp_valid[issue_warp_o] && !bar_wait[issue_warp_o]));
  // R11
  no_lost_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req) |-> issue_valid_o);
  // R9
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|req) |-> !issue_valid_o);

endmodule

// File: tb/wsched_issue_bench.sv
`timescale 1ns/1ps
module wsched_issue_bench;
  localparam int NW = 16;
  localparam int NR = 32;
  localparam int WW = 4;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          alloc_v = 0, retire_v = 0, wb_v = 0, ldd_v = 0, arr_v = 0;
  logic [WW-1:0] alloc_w = 0, retire_w = 0, wb_w = 0, ldd_w = 0, arr_w = 0;
  logic [RW-1:0] wb_r = 0;
  logic [RW-1:0] f_sa [NW];
  logic [RW-1:0] f_sb [NW];
  logic [RW-1:0] f_dd [NW];
  logic          f_hd [NW];
  logic          f_il [NW];
  logic          f_dl [NW];
  logic [NW*RW-1:0] src_a, src_b, dst;
  logic [NW-1:0]    hd_v, il_v, dl_v;
  logic             iss_v;
  logic [WW-1:0]    iss_w;

  always_comb begin
    for (int w = 0; w < NW; w++) begin
      src_a[w*RW +: RW] = f_sa[w];
      src_b[w*RW +: RW] = f_sb[w];
      dst[w*RW +: RW]   = f_dd[w];
      hd_v[w] = f_hd[w];
      il_v[w] = f_il[w];
      dl_v[w] = f_dl[w];
    end
  end

  wsched_issue u_wsched_issue (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_valid_i(alloc_v), .alloc_warp_i(alloc_w),
    .retire_valid_i(retire_v), .retire_warp_i(retire_w),
    .src_a_i(src_a), .src_b_i(src_b), .dst_i(dst),
    .has_dst_i(hd_v), .is_load_i(il_v), .dep_load_i(dl_v),
    .wb_valid_i(wb_v), .wb_warp_i(wb_w), .wb_reg_i(wb_r),
    .ld_done_valid_i(ldd_v), .ld_done_warp_i(ldd_w),
    .bar_arrive_valid_i(arr_v), .bar_arrive_warp_i(arr_w),
    .issue_valid_o(iss_v), .issue_warp_o(iss_w)
  );

  // behavioural reference state
  bit m_valid [NW];
  bit m_pend  [NW][NR];
  bit m_ldp   [NW];
  bit m_wait  [NW];
  int m_last;
  int n_cmp = 0, n_bad = 0;
  bit rand_fields = 0;
  string tag = "R1";

  function automatic bit m_ready(int w);
    return m_valid[w] && !m_pend[w][f_sa[w]] && !m_pend[w][f_sb[w]]
           && !(m_ldp[w] && f_dl[w]) && !m_wait[w];
  endfunction

  task automatic step();
    bit ev; int eg; int nres; int nwait; bit rel; bit vold [NW]; bit arr_ok;
    #1;
    ev = 0; eg = 0;
    for (int k = 1; k <= NW; k++) begin
      int idx;
      idx = (m_last + k) % NW;
      if (!ev && m_ready(idx)) begin ev = 1; eg = idx; end
    end
    n_cmp++;
    if (iss_v !== ev) begin
      n_bad++;
      $display("FAIL %s issue_valid act=%0b exp=%0b t=%0t", tag, iss_v, ev, $time);
    end
    if (ev && iss_v) begin
      n_cmp++;
      if (int'(iss_w) != eg) begin
        n_bad++;
        $display("FAIL %s issue_warp act=%0d exp=%0d t=%0t", tag, iss_w, eg, $time);
      end
    end
    @(posedge clk);
    nres = 0; nwait = 0;
    for (int w = 0; w < NW; w++) begin
      vold[w] = m_valid[w];
      nres += m_valid[w];
      nwait += m_wait[w];
    end
    rel = (nwait != 0) && (nwait == nres);
    arr_ok = arr_v && vold[arr_w] && !m_wait[arr_w];
    for (int w = 0; w < NW; w++) begin
      bit clr;
      clr = (alloc_v && alloc_w == w) || (retire_v && retire_w == w);
      if (alloc_v && alloc_w == w) begin
        m_valid[w] = 1; m_ldp[w] = 0;
        for (int r = 0; r < NR; r++) m_pend[w][r] = 0;
      end else begin
        if (retire_v && retire_w == w) m_valid[w] = 0;
        if (wb_v && wb_w == w) m_pend[w][wb_r] = 0;
        if (ev && eg == w && f_hd[w]) m_pend[w][f_dd[w]] = 1;
        if (ldd_v && ldd_w == w) m_ldp[w] = 0;
        if (ev && eg == w && f_il[w]) m_ldp[w] = 1;
      end
      if (rel) m_wait[w] = 0;
      else m_wait[w] = !clr && (m_wait[w] || (arr_ok && arr_w == w));
    end
    if (ev) m_last = eg;
    @(negedge clk);
    alloc_v = 0; retire_v = 0; wb_v = 0; ldd_v = 0; arr_v = 0;
    if (rand_fields && ev) begin
      f_sa[eg] = RW'($urandom_range(1, 7));
      f_sb[eg] = RW'($urandom_range(1, 7));
      f_dd[eg] = RW'($urandom_range(1, 7));
      f_hd[eg] = ($urandom_range(0, 1) == 1);
      f_il[eg] = ($urandom_range(0, 3) == 0);
      f_dl[eg] = ($urandom_range(0, 2) == 0);
    end
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_alloc(int w);   alloc_v = 1; alloc_w = WW'(w); step(); endtask
  task automatic do_retire(int w);  retire_v = 1; retire_w = WW'(w); step(); endtask
  task automatic do_arrive(int w);  arr_v = 1; arr_w = WW'(w); step(); endtask
  task automatic do_wb(int w, int r); wb_v = 1; wb_w = WW'(w); wb_r = RW'(r); step(); endtask

  initial begin
    #(200000 * 5.0);
    n_bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int w = 0; w < NW; w++) begin
      f_sa[w] = 1; f_sb[w] = 2; f_dd[w] = 3;
      f_hd[w] = 0; f_il[w] = 0; f_dl[w] = 0;
      m_valid[w] = 0; m_ldp[w] = 0; m_wait[w] = 0;
      for (int r = 0; r < NR; r++) m_pend[w][r] = 0;
    end
    m_last = NW - 1;
    repeat (3) @(negedge clk);
    // R1: nothing resident after reset
    n_cmp++;
    if (iss_v !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 issue_valid in reset act=%0b exp=0", iss_v);
    end
    rst_n = 1;
    @(negedge clk);
    tag = "R1"; steps(3);

    // R10 / R8: allocation and round-robin rotation
    tag = "R10";
    for (int w = 0; w < 4; w++) do_alloc(w);
    tag = "R8"; steps(9);

    // R3: warp 1 reads its own destination
    tag = "R3";
    f_hd[1] = 1; f_dd[1] = 5; f_sa[1] = 5;
    steps(6);
    do_wb(1, 5);
    steps(4);
    f_hd[1] = 0; f_sa[1] = 1;
    do_wb(1, 5);

    // R4: writeback racing an issue of the same register
    tag = "R4";
    do_retire(1); do_retire(2); do_retire(3);
    f_hd[0] = 1; f_dd[0] = 7;
    steps(2);
    do_wb(0, 7);
    f_sa[0] = 7;
    steps(3);
    do_wb(0, 7);
    f_hd[0] = 0; f_sa[0] = 1;
    steps(2);

    // R5: outstanding load blocks a dependent warp only
    tag = "R5";
    do_alloc(1); do_alloc(2);
    f_il[2] = 1; f_dl[2] = 1;
    steps(6);
    ldd_v = 1; ldd_w = 2; step();
    f_il[2] = 0;
    steps(4);
    f_dl[2] = 0;
    steps(2);

    // R6 / R7 / R9: barrier over warps 0..2
    tag = "R6";
    do_arrive(0);
    do_arrive(0);
    do_arrive(9);
    steps(2);
    do_arrive(1);
    steps(2);
    tag = "R7";
    do_arrive(2);
    tag = "R9"; step();
    tag = "R7"; steps(4);

    // R10: retire of a waiting warp, then alloc beating retire
    tag = "R10";
    do_arrive(0);
    do_retire(0);
    do_arrive(1);
    steps(2);
    do_arrive(2);
    steps(3);
    alloc_v = 1; alloc_w = 0; retire_v = 1; retire_w = 0; step();
    steps(4);

    // R2 / R11: random traffic
    tag = "R11";
    rand_fields = 1;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 15) == 0) begin alloc_v = 1; alloc_w = WW'($urandom_range(0, NW-1)); end
      if ($urandom_range(0, 40) == 0) begin retire_v = 1; retire_w = WW'($urandom_range(0, NW-1)); end
      if ($urandom_range(0, 1) == 0) begin
        wb_v = 1; wb_w = WW'($urandom_range(0, NW-1)); wb_r = RW'($urandom_range(1, 7));
      end
      if ($urandom_range(0, 3) == 0) begin ldd_v = 1; ldd_w = WW'($urandom_range(0, NW-1)); end
      if ($urandom_range(0, 7) == 0) begin arr_v = 1; arr_w = WW'($urandom_range(0, NW-1)); end
      tag = (i % 2 == 0) ? "R2" : "R11";
      step();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule